// File: doc/BRIEF.md
# Receive FIFO Interrupt and Character Timeout Controller

This block turns receive-FIFO occupancy and host activity into the receiver interrupt conditions of a UART with a 16-entry receive FIFO. It compares the occupancy count from the FIFO with a programmable trigger level to raise a data-available condition. It keeps a data-ready flag. It also runs a character-timeout timer, so that a few bytes left below the trigger level still get serviced once the line goes quiet.

The timer counts baud-rate clock enables. One character time is sixteen enables per bit. The bit count of a character comes from the programmed data length, the parity setting and the stop-bit setting. The timer restarts on every arrival and every host read, and it fires after four quiet character times. A prioritised identification code reports the most urgent cause: line-status errors first, then the receive conditions, or a no-interrupt code when nothing is pending. The serial receiver, the FIFO storage and the host bus logic sit outside this block and connect through the ports below.

Top module: `rx_irq_ctrl`

## Requirements
- R1: `data_avail` is high in the same cycle that `fifo_count` is at or above the trigger level. The trigger level is selected by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R2: `data_avail` falls in the same cycle that `fifo_count` drops below the trigger level, whether the drop comes from a host read or from a change of `trig_sel`.
- R3: `data_ready` is set in the cycle after `push`. It is cleared in the cycle after a clock edge at which `fifo_count` is 0 and `push` is low. Otherwise it holds.
- R4: `char_timeout` rises once the timer has counted 64 × (bits per character) `baud_tick` pulses. The count must run without any `push` or `pop` while `fifo_count` is nonzero.
- R5: The number of bits per character is 1 + (5 + `word_len`) + `parity_en` + (1 + `stop2`). With `stop2` set, the second stop bit is therefore part of the timeout delay.
- R6: A `pop` clears `char_timeout` and restarts the timer from the next edge. A `push` restarts the timer but does not clear a timeout that has already fired.
- R7: `irq_id` is 0x6 when a line-status interrupt is active. Otherwise it is 0xC when the timeout interrupt is active, 0x4 when the data-available interrupt is active, and 0x1 when nothing is pending. `irq` is high exactly when `irq_id` is not 0x1.
- R8: When `fifo_en` is low, no interrupt is reported and the timer and timeout are held clear. `ie_rls` gates the line-status interrupt. `ie_rda` gates both the data-available interrupt and the timeout interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Receive FIFO enable |
| ie_rda | input | 1 | Enable for the data-available and timeout interrupts |
| ie_rls | input | 1 | Enable for the line-status interrupt |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| baud_tick | input | 1 | Baud-rate clock enable (16 per bit) |
| fifo_count | input | 5 | Receive FIFO occupancy |
| push | input | 1 | Character moved into the FIFO |
| pop | input | 1 | Host read of the FIFO |
| line_err | input | 1 | Pending line-status error |
| data_ready | output | 1 | Data-ready flag |
| data_avail | output | 1 | Occupancy at or above the trigger level |
| char_timeout | output | 1 | Character timeout has fired |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Prioritised identification code |

## Verification
The hardest condition to reach from the ports is a timeout that has already fired and then meets a new arrival before any host read. It requires hundreds of quiet cycles at an exact baud rate followed by a single push. The stimulus fills the FIFO below the trigger level and holds the baud enable at a known cadence until the timeout fires. It then pushes one byte, waits, and reads once, with the reference model tracking the timer on every cycle. The timeout-length checks repeat this under the shortest and longest character formats and at two baud cadences, so that the firing cycle is compared exactly.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_RDA  = 4'h4,
        IID_RLS  = 4'h6,
        IID_CTO  = 4'hC
    } iid_e;

    typedef struct packed {
        logic rls;
        logic cto;
        logic rda;
    } irq_req_t;

    // occupancy threshold chosen by the 2-bit trigger select
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // start + data + parity + stop bits of one character
    function automatic int char_bits(input logic [1:0] wl, input logic par, input logic two_stop);
        return 1 + 5 + int'(wl) + int'(par) + 1 + int'(two_stop);
    endfunction

endpackage

// File: rtl/rx_level_cmp.sv
module rx_level_cmp
    import rx_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             at_level
);
    always_comb begin
        at_level = int'(fifo_count) >= trig_level(trig_sel, DEPTH);
    end
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_ok,
    input  logic             push,
    input  logic             pop,
    input  logic             baud_tick,
    input  logic [TMR_W-1:0] limit,
    output logic             fired
);
    logic [TMR_W-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || !run_ok || pop) begin
            ticks <= '0;
            fired <= 1'b0;
        end else if (push) begin
            ticks <= '0;
        end else if (baud_tick && !fired) begin
            ticks <= ticks + 1'b1;
            if (ticks + 1'b1 == limit)
                fired <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio
    import rx_irq_pkg::*;
(
    input  irq_req_t   req,
    output logic [3:0] id
);
    iid_e code;
    always_comb begin
        if (req.rls)      code = IID_RLS;
        else if (req.cto) code = IID_CTO;
        else if (req.rda) code = IID_RDA;
        else              code = IID_NONE;
        id = code;
    end
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rx_irq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int OVERSAMPLE = 16,
    parameter int TO_CHARS   = 4,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int MAX_BITS  = 12,
    localparam int TMR_W     = $clog2(MAX_BITS * OVERSAMPLE * TO_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             ie_rda,
    input  logic             ie_rls,
    input  logic [1:0]       trig_sel,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             stop2,
    input  logic             baud_tick,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             push,
    input  logic             pop,
    input  logic             line_err,
    output logic             data_ready,
    output logic             data_avail,
    output logic             char_timeout,
    output logic             irq,
    output logic [3:0]       irq_id
);
    logic             fifo_nz;
    logic [TMR_W-1:0] to_limit;
    irq_req_t         req;

    assign fifo_nz  = fifo_count != '0;
    assign to_limit = TMR_W'(char_bits(word_len, parity_en, stop2) * OVERSAMPLE * TO_CHARS);

    rx_level_cmp #(.DEPTH(DEPTH)) u_lvl (
        .trig_sel   (trig_sel),
        .fifo_count (fifo_count),
        .at_level   (data_avail)
    );

    rx_char_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .run_ok    (fifo_en && fifo_nz),
        .push      (push),
        .pop       (pop),
        .baud_tick (baud_tick),
        .limit     (to_limit),
        .fired     (char_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_ready <= 1'b0;
        else if (push)
            data_ready <= 1'b1;
        else if (!fifo_nz)
            data_ready <= 1'b0;
    end

    always_comb begin
        req.rls = fifo_en && ie_rls && line_err;
        req.cto = fifo_en && ie_rda && char_timeout;
        req.rda = fifo_en && ie_rda && data_avail;
    end

    rx_irq_prio u_prio (
        .req (req),
        .id  (irq_id)
    );

    assign irq = irq_id != IID_NONE;
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             ie_rls,
    input logic [CNT_W-1:0] fifo_count,
    input logic             push,
    input logic             pop,
    input logic             line_err,
    input logic             data_ready,
    input logic             data_avail,
    input logic             char_timeout,
    input logic             irq,
    input logic [3:0]       irq_id
);
    // R3
    dr_set_chk: assert property (@(posedge clk) disable iff (rst) push |=> data_ready);
    // R6
    pop_clr_chk: assert property (@(posedge clk) disable iff (rst) pop |=> !char_timeout);
    // R4
    to_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(char_timeout) |-> ($past(fifo_count) != '0));
    // R1
    avail_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        data_avail |-> (fifo_count != '0));
    // R7
    rls_top_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ie_rls && line_err) |-> (irq_id == 4'h6));
    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_id != 4'h1));
    // R8
    fifo_off_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (irq_id == 4'h1));
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;
    logic       clk = 0;
    logic       rst = 1;
    logic       fifo_en = 0, ie_rda = 0, ie_rls = 0;
    logic [1:0] trig_sel = 0, word_len = 0;
    logic       parity_en = 0, stop2 = 0, baud_tick = 0;
    logic [4:0] fifo_count = 0;
    logic       push = 0, pop = 0, line_err = 0;
    logic       data_ready, data_avail, char_timeout, irq;
    logic [3:0] irq_id;

    int n_cmp = 0, n_bad = 0;
    int occ = 0;
    int m_dr = 0, m_to = 0, m_t = 0;
    string phase = "R1";
    int tick_div = 1, cyc_n = 0;

    always #2.5 clk = ~clk;

    rx_irq_ctrl u_dut (.*);

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic int lvl();
        case (trig_sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int lim();
        return 64 * (1 + 5 + int'(word_len) + int'(parity_en) + 1 + int'(stop2));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s]: actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    task automatic compare();
        int e_id;
        bit rls, cto, rda;
        rls = fifo_en && ie_rls && line_err;
        cto = fifo_en && ie_rda && (m_to != 0);
        rda = fifo_en && ie_rda && (occ >= lvl());
        e_id = rls ? 6 : cto ? 12 : rda ? 4 : 1;
        chk("R1", int'(data_avail), int'(occ >= lvl()));
        chk("R3", int'(data_ready), m_dr);
        chk("R4", int'(char_timeout), m_to);
        chk("R7", int'(irq_id), e_id);
        chk("R7", int'(irq), int'(e_id != 1));
    endtask

    task automatic cyc(input bit p, input bit q);
        push = p; pop = q;
        baud_tick = (cyc_n % tick_div) == 0;
        cyc_n++;
        @(posedge clk);
        if (rst) begin
            m_dr = 0; m_to = 0; m_t = 0;
        end else begin
            if (p) m_dr = 1; else if (occ == 0) m_dr = 0;
            if (!fifo_en || occ == 0 || q) begin m_t = 0; m_to = 0; end
            else if (p) m_t = 0;
            else if (baud_tick && m_to == 0) begin
                m_t++;
                if (m_t == lim()) m_to = 1;
            end
        end
        occ = occ + int'(p) - int'(q);
        @(negedge clk);
        fifo_count = 5'(occ);
        #0.5;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0);
    endtask

    initial begin
        @(negedge clk);
        cyc(0, 0); cyc(0, 0);
        rst = 0;
        phase = "reset R3 R7";
        cyc(0, 0);
        fifo_en = 1; ie_rda = 1; ie_rls = 1;

        // trigger levels up and down
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            phase = "R1 fill";
            for (int i = 0; i < 15; i++) cyc(1, 0);
            phase = "R2 drain";
            for (int i = 0; i < 15; i++) cyc(0, 1);
            cyc(0, 0); cyc(0, 0);
        end
        phase = "R2 trig change";
        for (int i = 0; i < 6; i++) cyc(1, 0);
        trig_sel = 2; cyc(0, 0);
        trig_sel = 1; cyc(0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 1);
        idle(2);

        // timeout, short format, tick every cycle
        trig_sel = 3; word_len = 0; parity_en = 0; stop2 = 0;
        phase = "R4 R5 short";
        cyc(1, 0); cyc(1, 0);
        idle(460);
        phase = "R6 push keeps";
        cyc(1, 0); idle(10);
        phase = "R6 pop clears";
        cyc(0, 1); idle(30);
        phase = "R6 push restarts";
        idle(200); cyc(1, 0); idle(300);
        cyc(0, 1); cyc(0, 1); cyc(0, 1); idle(4);

        // long format with second stop bit, half baud rate
        word_len = 3; parity_en = 1; stop2 = 1; tick_div = 2;
        phase = "R5 long stop2";
        cyc(1, 0);
        idle(1560);
        phase = "R7 prio";
        line_err = 1; idle(3); line_err = 0;
        cyc(1, 0); cyc(1, 0); cyc(1, 0); idle(2);
        trig_sel = 0; idle(2);
        line_err = 1; idle(2); line_err = 0; idle(2);

        phase = "R8 gating";
        ie_rls = 0; line_err = 1; idle(3);
        ie_rda = 0; idle(3);
        ie_rda = 1; ie_rls = 1; fifo_en = 0; idle(5);
        line_err = 0; fifo_en = 1; tick_div = 1;
        phase = "R8 timer cleared";
        idle(10);
        phase = "R3 empty";
        for (int i = 0; i < 4; i++) cyc(0, 1);
        idle(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule